// File: doc/BRIEF.md
# Mode-Banked General Register File

This block is the general register storage of a 32-bit processor core. The datapath always sees sixteen registers, numbered 0 to 15. Register 13 serves as the stack pointer, 14 as the link register and 15 as the program counter, which is held here as plain storage. The physical copy behind a register number depends on the processor mode presented on the `mode` input. When an exception mode is entered, its private copies of some registers replace the user copies. The user copies are left untouched, so the interrupted program's values survive.

Each cycle the file serves two source reads, one destination write and a saved-status access for the current mode. A second path always addresses the user-mode copies, whatever the current mode is. Privileged code uses it to save and restore a user context. All read results are registered and appear one clock after their select is applied. A write lands on the clock edge, so a read issued in the same cycle as a write to the same register returns the earlier contents.

Top module: `banked_regfile`

## Requirements
- R1: Synchronous active-high `rst` clears every general register, every saved status register and all read outputs to zero.
- R2: `rn_data` and `rm_data` show the register selected by `rn_sel` and `rm_sel`, resolved under the current mode. They appear one clock after the select is applied.
- R3: When `rd_we` is high, `rd_wdata` is stored at the clock edge into the register that `rd_sel` selects under the current mode. A read of that same register issued in the same cycle returns the value it held before the write.
- R4: Mode codes are 5 bits. User mode is 10000 and system mode is 11111. Both of these codes, and every code that is not listed in R5 or R6, access the same sixteen user registers.
- R5: Fast-interrupt mode (10001) has its own copies of registers 8 to 14. Writing them leaves the user copies unchanged. Registers 0 to 7 and 15 are shared with user mode.
- R6: Interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes each have their own private copies of registers 13 and 14. All other registers are shared with user mode.
- R7: Register 15 is a single location that every mode reads and writes.
- R8: `ub_sel`, `ub_rdata`, `ub_we` and `ub_wdata` always address the user copy, whatever the mode, and the read appears after one clock. If `rd_we` and `ub_we` target the same physical register in one cycle, the `rd_wdata` value is kept.
- R9: Each of the five exception modes has one saved status register, selected by the current mode. `sr_we` writes `sr_wdata` into it. `sr_rdata` shows its value one clock later, and a same-cycle write does not affect that read.
- R10: In user mode, system mode or an unlisted mode code, `sr_rdata` reads zero and `sr_we` changes no saved status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 5 | Current processor mode code |
| rn_sel | input | 4 | First source register number |
| rm_sel | input | 4 | Second source register number |
| rn_data | output | 32 | First source data, registered |
| rm_data | output | 32 | Second source data, registered |
| rd_we | input | 1 | Destination write enable |
| rd_sel | input | 4 | Destination register number |
| rd_wdata | input | 32 | Destination write data |
| ub_sel | input | 4 | User-copy register number for read and write |
| ub_we | input | 1 | User-copy write enable |
| ub_wdata | input | 32 | User-copy write data |
| ub_rdata | output | 32 | User-copy read data, registered |
| sr_we | input | 1 | Saved status write enable for the current mode |
| sr_wdata | input | 32 | Saved status write data |
| sr_rdata | output | 32 | Saved status of the current mode, registered |

## Verification
Every result of this block is due exactly one clock edge after the cycle that presents its select, mode and write inputs: `rn_data`, `rm_data`, `ub_rdata` and `sr_rdata` all follow this rule. A write is visible only to reads issued in later cycles. The driver applies inputs on the falling edge and tags each expected value with the number of the rising edge at which it becomes due. The monitor compares each value shortly after that edge, and it flags a value that is missing or that arrives late. Same-cycle read-and-write cases are expected to return the old value, which confirms that the one-edge timing holds for the collision case as well.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int VIS_REGS   = 16;
  localparam int IDX_W      = $clog2(VIS_REGS);
  localparam int SP_IDX     = 13;
  localparam int LR_IDX     = 14;
  localparam int PC_IDX     = 15;
  localparam int FIQ_FIRST  = 8;
  localparam int FIQ_BANKED = LR_IDX - FIQ_FIRST + 1;
  localparam int EXC_BANKED = LR_IDX - SP_IDX + 1;
  localparam int EXC_MODES  = 4;
  localparam int PHYS_REGS  = VIS_REGS + FIQ_BANKED + EXC_MODES * EXC_BANKED;
  localparam int PHYS_W     = $clog2(PHYS_REGS);
  localparam int SAVED_REGS = EXC_MODES + 1;
  localparam int MODE_W     = 5;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  localparam logic [MODE_W-1:0] MC_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MC_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MC_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MC_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MC_UND = 5'b11011;

  // User, system and unknown codes all fall to the user bank.
  function automatic bank_e bank_of(input logic [MODE_W-1:0] m);
    bank_e b;
    case (m)
      MC_FIQ:  b = BK_FIQ;
      MC_IRQ:  b = BK_IRQ;
      MC_SVC:  b = BK_SVC;
      MC_ABT:  b = BK_ABT;
      MC_UND:  b = BK_UND;
      default: b = BK_USR;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/bank_map.sv
module bank_map
  import regbank_pkg::*;
(
  input  bank_e             bank,
  input  logic [IDX_W-1:0]  vis,
  output logic [PHYS_W-1:0] phys
);
  localparam int OTH_BASE = VIS_REGS + FIQ_BANKED;

  always_comb begin
    int v;
    v    = int'(vis);
    phys = PHYS_W'(v);
    if (bank == BK_FIQ && v >= FIQ_FIRST && v <= LR_IDX) begin
      phys = PHYS_W'(VIS_REGS + v - FIQ_FIRST);
    end else if (bank != BK_USR && bank != BK_FIQ && v >= SP_IDX && v <= LR_IDX) begin
      phys = PHYS_W'(OTH_BASE + (int'(bank) - int'(BK_IRQ)) * EXC_BANKED + v - SP_IDX);
    end
  end

  always_comb begin
    if (!$isunknown({bank, vis})) begin
      // R7: the program counter index never leaves its single slot
      assert_pc_single_R7: assert (int'(vis) != PC_IDX || int'(phys) == PC_IDX)
        else $error("program counter mapped away from shared slot");
      // R4: user bank is an identity mapping
      assert_user_identity_R4: assert (bank != BK_USR || int'(phys) == int'(vis))
        else $error("user bank mapping not identity");
      assert_slot_range_R5: assert (int'(phys) < PHYS_REGS)
        else $error("physical slot out of range");
    end
  end
endmodule

// File: rtl/gpr_store.sv
module gpr_store #(
  parameter int DW   = 32,
  parameter int NREG = 31,
  parameter int AW   = 5,
  parameter int NRD  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][DW-1:0]  rdata,
  input  logic                    we_a,
  input  logic [AW-1:0]           wa_a,
  input  logic [DW-1:0]           wd_a,
  input  logic                    we_b,
  input  logic [AW-1:0]           wa_b,
  input  logic [DW-1:0]           wd_b
);
  logic [DW-1:0] mem [NREG];

  // Port b first, port a last: port a wins a same-slot collision.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else begin
      if (we_b) mem[wa_b] <= wd_b;
      if (we_a) mem[wa_a] <= wd_a;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst) rdata[g] <= '0;
      else     rdata[g] <= mem[raddr[g]];
    end
  end

  // R3: a main write is present in storage after the edge
  assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
    we_a |=> mem[$past(wa_a)] == $past(wd_a))
    else $error("main write lost");

  // R8: a user-path write lands unless the main port hits the same slot
  assert_ub_lands_R8: assert property (@(posedge clk) disable iff (rst)
    (we_b && !(we_a && wa_a == wa_b)) |=> mem[$past(wa_b)] == $past(wd_b))
    else $error("user-path write lost");
endmodule

// File: rtl/spsr_store.sv
module spsr_store
  import regbank_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  bank_e         bank,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int SW = $clog2(SAVED_REGS);

  logic [SAVED_REGS-1:0][DW-1:0] ss;
  logic [SAVED_REGS-1:0]         wen;
  logic [SW-1:0]                 sel;

  assign sel = (bank == BK_USR) ? '0 : SW'(int'(bank) - 1);

  for (genvar k = 0; k < SAVED_REGS; k++) begin : g_ss
    assign wen[k] = we && (int'(bank) == k + 1);
    always_ff @(posedge clk) begin
      if (rst)         ss[k] <= '0;
      else if (wen[k]) ss[k] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || bank == BK_USR) rdata <= '0;
    else                       rdata <= ss[sel];
  end

  // R9: an exception-mode write reaches its own saved register
  assert_ss_write_R9: assert property (@(posedge clk) disable iff (rst)
    (we && bank != BK_USR) |=> ss[$past(sel)] == $past(wdata))
    else $error("saved status write lost");

  // R10: no saved register moves while in a user-bank mode
  assert_ss_nowrite_R10: assert property (@(posedge clk) disable iff (rst)
    (bank == BK_USR) |=> $stable(ss))
    else $error("saved status changed from user bank");

  // R10: user-bank modes read zero
  assert_ss_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (bank == BK_USR) |=> rdata == '0)
    else $error("saved status visible from user bank");
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic [IDX_W-1:0]  rn_sel,
  input  logic [IDX_W-1:0]  rm_sel,
  output logic [DATA_W-1:0] rn_data,
  output logic [DATA_W-1:0] rm_data,
  input  logic              rd_we,
  input  logic [IDX_W-1:0]  rd_sel,
  input  logic [DATA_W-1:0] rd_wdata,
  input  logic [IDX_W-1:0]  ub_sel,
  input  logic              ub_we,
  input  logic [DATA_W-1:0] ub_wdata,
  output logic [DATA_W-1:0] ub_rdata,
  input  logic              sr_we,
  input  logic [DATA_W-1:0] sr_wdata,
  output logic [DATA_W-1:0] sr_rdata
);
  localparam int NMAP = 4;   // rn, rm, rd, user path
  localparam int NRD  = 3;

  bank_e                       cur_bank;
  bank_e                       pbank [NMAP];
  logic [NMAP-1:0][IDX_W-1:0]  vsel;
  logic [NMAP-1:0][PHYS_W-1:0] phys;
  logic [NRD-1:0][PHYS_W-1:0]  raddr;
  logic [NRD-1:0][DATA_W-1:0]  rdata;

  assign cur_bank = bank_of(mode);
  assign vsel     = {ub_sel, rd_sel, rm_sel, rn_sel};

  always_comb begin
    for (int i = 0; i < NMAP - 1; i++) pbank[i] = cur_bank;
    pbank[NMAP-1] = BK_USR;
  end

  for (genvar g = 0; g < NMAP; g++) begin : g_map
    bank_map u_map (
      .bank (pbank[g]),
      .vis  (vsel[g]),
      .phys (phys[g])
    );
  end

  assign raddr = {phys[3], phys[1], phys[0]};

  gpr_store #(
    .DW   (DATA_W),
    .NREG (PHYS_REGS),
    .AW   (PHYS_W),
    .NRD  (NRD)
  ) u_gpr (
    .clk   (clk),
    .rst   (rst),
    .raddr (raddr),
    .rdata (rdata),
    .we_a  (rd_we),
    .wa_a  (phys[2]),
    .wd_a  (rd_wdata),
    .we_b  (ub_we),
    .wa_b  (phys[3]),
    .wd_b  (ub_wdata)
  );

  assign rn_data  = rdata[0];
  assign rm_data  = rdata[1];
  assign ub_rdata = rdata[2];

  spsr_store #(.DW(DATA_W)) u_ss (
    .clk   (clk),
    .rst   (rst),
    .bank  (cur_bank),
    .we    (sr_we),
    .wdata (sr_wdata),
    .rdata (sr_rdata)
  );
endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
  localparam logic [4:0] USR = 5'b10000;
  localparam logic [4:0] SYS = 5'b11111;
  localparam logic [4:0] FIQ = 5'b10001;
  localparam logic [4:0] IRQ = 5'b10010;
  localparam logic [4:0] SVC = 5'b10011;
  localparam logic [4:0] ABT = 5'b10111;
  localparam logic [4:0] UND = 5'b11011;
  localparam int P_RN = 0, P_RM = 1, P_UB = 2, P_SR = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  mode = USR;
  logic [3:0]  rn_sel = '0, rm_sel = '0, rd_sel = '0, ub_sel = '0;
  logic        rd_we = 1'b0, ub_we = 1'b0, sr_we = 1'b0;
  logic [31:0] rd_wdata = '0, ub_wdata = '0, sr_wdata = '0;
  logic [31:0] rn_data, rm_data, ub_rdata, sr_rdata;

  always #2.5 clk = ~clk;

  banked_regfile u_dut (
    .clk(clk), .rst(rst), .mode(mode),
    .rn_sel(rn_sel), .rm_sel(rm_sel), .rn_data(rn_data), .rm_data(rm_data),
    .rd_we(rd_we), .rd_sel(rd_sel), .rd_wdata(rd_wdata),
    .ub_sel(ub_sel), .ub_we(ub_we), .ub_wdata(ub_wdata), .ub_rdata(ub_rdata),
    .sr_we(sr_we), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata)
  );

  typedef struct {
    int          due;
    int          port;
    logic [31:0] val;
    string       req;
  } exp_t;

  exp_t        q[$];
  exp_t        e;
  int          cyc = 0;
  int          n_cmp = 0;
  int          n_bad = 0;
  logic [31:0] act;
  bit          done = 0;

  // Monitor: compare every item due at this edge, shortly after it.
  always @(posedge clk) begin
    cyc = cyc + 1;
    #1;
    while (q.size() > 0 && q[0].due <= cyc) begin
      e = q.pop_front();
      case (e.port)
        P_RN:    act = rn_data;
        P_RM:    act = rm_data;
        P_UB:    act = ub_rdata;
        default: act = sr_rdata;
      endcase
      n_cmp++;
      if (e.due != cyc || act !== e.val) begin
        n_bad++;
        $display("FAIL %s port %0d edge %0d (due %0d): got %h expected %h",
                 e.req, e.port, cyc, e.due, act, e.val);
      end
    end
  end

  task automatic op(input logic [4:0] m, input logic [3:0] a,
                    input logic [3:0] b, input logic [3:0] u);
    @(negedge clk);
    mode = m; rn_sel = a; rm_sel = b; ub_sel = u;
    rd_we = 1'b0; ub_we = 1'b0; sr_we = 1'b0;
  endtask

  task automatic w(input logic [3:0] i, input logic [31:0] v);
    rd_we = 1'b1; rd_sel = i; rd_wdata = v;
  endtask

  task automatic ex(input int port, input logic [31:0] v, input string req);
    exp_t it;
    it.due = cyc + 1; it.port = port; it.val = v; it.req = req;
    q.push_back(it);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  logic [4:0] xm [4];

  initial begin
    xm[0] = IRQ; xm[1] = SVC; xm[2] = ABT; xm[3] = UND;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    op(IRQ, 0, 15, 3);
    ex(P_RN, 0, "R1"); ex(P_RM, 0, "R1"); ex(P_UB, 0, "R1"); ex(P_SR, 0, "R1");

    // Fill the user bank
    for (int i = 0; i < 16; i++) begin
      op(USR, 0, 0, 0);
      w(4'(i), 32'h1000 + 32'(i));
    end
    // R2: one-cycle read
    op(USR, 3, 15, 0);
    ex(P_RN, 32'h1003, "R2"); ex(P_RM, 32'h100F, "R2");
    // R3: same-cycle read sees old value, next read sees new
    op(USR, 5, 5, 0); w(5, 32'hAAAA);
    ex(P_RN, 32'h1005, "R3"); ex(P_RM, 32'h1005, "R3");
    op(USR, 5, 0, 0);
    ex(P_RN, 32'hAAAA, "R3"); ex(P_RM, 32'h1000, "R2");

    // R4: system and unknown codes share the user bank
    op(SYS, 13, 14, 0);
    ex(P_RN, 32'h100D, "R4"); ex(P_RM, 32'h100E, "R4");
    op(SYS, 0, 0, 0); w(2, 32'h2222);
    op(USR, 2, 0, 0);
    ex(P_RN, 32'h2222, "R4");
    op(5'b00000, 14, 2, 0);
    ex(P_RN, 32'h100E, "R4"); ex(P_RM, 32'h2222, "R4");
    op(5'b10110, 15, 0, 0);
    ex(P_RN, 32'h100F, "R4");

    // R5: fast-interrupt bank of 8..14
    op(FIQ, 8, 7, 0);
    ex(P_RN, 0, "R5"); ex(P_RM, 32'h1007, "R5");
    op(FIQ, 0, 0, 0); w(8, 32'hF008);
    op(FIQ, 0, 0, 0); w(14, 32'hF00E);
    op(USR, 8, 14, 0);
    ex(P_RN, 32'h1008, "R5"); ex(P_RM, 32'h100E, "R5");
    op(FIQ, 8, 14, 0);
    ex(P_RN, 32'hF008, "R5"); ex(P_RM, 32'hF00E, "R5");
    op(FIQ, 12, 0, 0);
    ex(P_RN, 0, "R5");

    // R6: four modes each bank 13 and 14
    for (int k = 0; k < 4; k++) begin
      op(xm[k], 0, 0, 0); w(13, 32'h5D00 + 32'(k));
      op(xm[k], 0, 0, 0); w(14, 32'h5E00 + 32'(k));
    end
    for (int k = 0; k < 4; k++) begin
      op(xm[k], 13, 14, 0);
      ex(P_RN, 32'h5D00 + 32'(k), "R6"); ex(P_RM, 32'h5E00 + 32'(k), "R6");
    end
    op(IRQ, 12, 0, 0);
    ex(P_RN, 32'h100C, "R6");
    op(USR, 13, 14, 0);
    ex(P_RN, 32'h100D, "R6"); ex(P_RM, 32'h100E, "R6");
    op(FIQ, 13, 0, 0);
    ex(P_RN, 0, "R6");

    // R7: one shared program counter
    op(FIQ, 0, 0, 0); w(15, 32'hCAFE);
    op(IRQ, 15, 0, 0);
    ex(P_RN, 32'hCAFE, "R7");
    op(USR, 0, 15, 0);
    ex(P_RM, 32'hCAFE, "R7");
    op(UND, 15, 0, 0);
    ex(P_RN, 32'hCAFE, "R7");

    // R8: user-copy path
    op(SVC, 13, 0, 13);
    ex(P_RN, 32'h5D01, "R8"); ex(P_UB, 32'h100D, "R8");
    op(IRQ, 0, 0, 14); ub_we = 1'b1; ub_wdata = 32'hBEEF;
    op(USR, 14, 0, 0);
    ex(P_RN, 32'hBEEF, "R8");
    op(IRQ, 14, 0, 0);
    ex(P_RN, 32'h5E00, "R8");
    op(USR, 0, 0, 4); w(4, 32'h4444); ub_we = 1'b1; ub_wdata = 32'h9999;
    op(USR, 4, 0, 0);
    ex(P_RN, 32'h4444, "R8");
    op(FIQ, 0, 0, 9); w(9, 32'hF009); ub_we = 1'b1; ub_wdata = 32'h0909;
    op(FIQ, 9, 0, 9);
    ex(P_RN, 32'hF009, "R8"); ex(P_UB, 32'h0909, "R8");

    // R9: saved status per exception mode
    op(IRQ, 0, 0, 0); sr_we = 1'b1; sr_wdata = 32'h11; ex(P_SR, 0, "R9");
    op(SVC, 0, 0, 0); sr_we = 1'b1; sr_wdata = 32'h22;
    op(ABT, 0, 0, 0); sr_we = 1'b1; sr_wdata = 32'h33;
    op(UND, 0, 0, 0); sr_we = 1'b1; sr_wdata = 32'h44;
    op(FIQ, 0, 0, 0); sr_we = 1'b1; sr_wdata = 32'h55;
    op(IRQ, 0, 0, 0); ex(P_SR, 32'h11, "R9");
    op(SVC, 0, 0, 0); ex(P_SR, 32'h22, "R9");
    op(ABT, 0, 0, 0); ex(P_SR, 32'h33, "R9");
    op(UND, 0, 0, 0); ex(P_SR, 32'h44, "R9");
    op(FIQ, 0, 0, 0); ex(P_SR, 32'h55, "R9");

    // R10: no saved status in user-bank modes
    op(USR, 0, 0, 0); sr_we = 1'b1; sr_wdata = 32'h77; ex(P_SR, 0, "R10");
    op(SYS, 0, 0, 0); sr_we = 1'b1; sr_wdata = 32'h66; ex(P_SR, 0, "R10");
    op(5'b00011, 0, 0, 0); ex(P_SR, 0, "R10");
    op(IRQ, 0, 0, 0); ex(P_SR, 32'h11, "R10");
    op(FIQ, 0, 0, 0); ex(P_SR, 32'h55, "R10");
    op(UND, 0, 0, 0); ex(P_SR, 32'h44, "R10");

    // R1: reset in mid-run clears everything
    op(USR, 0, 0, 0);
    op(USR, 0, 0, 0);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    op(USR, 3, 15, 13);
    ex(P_RN, 0, "R1"); ex(P_RM, 0, "R1"); ex(P_UB, 0, "R1");
    op(FIQ, 8, 0, 0);
    ex(P_RN, 0, "R1"); ex(P_SR, 0, "R1");
    op(IRQ, 13, 0, 0);
    ex(P_RN, 0, "R1"); ex(P_SR, 0, "R1");

    op(USR, 0, 0, 0);
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R2: got %0d pending results expected 0", q.size());
    end
    done = 1;
    summary();
    $finish;
  end
endmodule